// File: doc/BRIEF.md
# SMRAM Window Control Register

This block holds an 8-bit configuration register that decides where processor accesses to the legacy graphics-memory window go. Such an access either reaches protected SMRAM or falls through to the normal memory or graphics path. Firmware opens the window to copy a handler into SMRAM, closes it again, and then sets a lock bit. The lock freezes every field until the next full reset.

Each access carries an address, a flag that says whether the processor is in system-management mode, and a flag that marks a code fetch. The block returns one routing decision for that access. The decision is combinational from the access inputs and the stored register. A configuration write takes effect at the next rising clock edge, and the register contents can be read at any time on the read port.

Top module: `smram_window_ctl`

## Requirements
- R1: After reset the read port shows 8'h02. That value is global enable clear, open, close and lock clear, and segment code 3'b010. No access is routed to SMRAM in this state.
- R2: While unlocked, a write updates the register at the next rising edge, and the read port shows the new value from then on. Bit 7 is reserved and always reads 0. An access in the cycle of the write is routed by the old value.
- R3: A write that sets both open (bit 6) and close (bit 5) stores close as 0 and keeps open.
- R4: A write with lock (bit 4) set stores open as 0. From then on every write is ignored until reset, so open can never return to 1.
- R5: With global enable (bit 3) clear, no access is routed to SMRAM, whatever the other bits hold.
- R6: With global enable and open set, an access inside the window reaches SMRAM even when the processor is not in SMM.
- R7: With global enable set and open clear, an access inside the window reaches SMRAM only while the processor is in SMM.
- R8: With close set and open clear, an SMM data access inside the window goes to normal space, and an SMM code fetch still reaches SMRAM.
- R9: Only addresses from 0xA0000 to 0xBFFFF inclusive can be routed to SMRAM.
- R10: The window is active only while the segment field (bits 2:0) holds 3'b010. Any other code routes every access to normal space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Current register contents |
| cpu_in_smm | input | 1 | Processor is in system-management mode |
| acc_addr | input | ADDR_W | Address of the current access |
| acc_fetch | input | 1 | Current access is a code fetch (1) or a data access (0) |
| acc_to_smram | output | 1 | Route the current access to SMRAM |

## Verification
A configuration write and a routed access can happen in the same cycle. In that cycle the routing must come from the value stored before the write and never from the incoming data. The bench provokes this by presenting a write that opens the window together with a non-SMM access inside the window. It expects normal-space routing and the old read value in that cycle, then SMRAM routing and the new value one clock later. The same pattern after lock shows that a write arriving with an access changes nothing in either cycle.

// File: rtl/smram_pkg.sv
// Package: field positions, codes and the register view shared by the
// SMRAM window control logic. Assumes the 8-bit layout below is fixed.
package smram_pkg;

    localparam int CFG_W = 8;

    // Segment code that selects the legacy graphics window
    localparam logic [2:0] SEG_LEGACY = 3'b010;

    // Value held after reset: legacy segment, all else off, unlocked
    localparam logic [CFG_W-1:0] CFG_RESET = 8'h02;

    // Register view, most significant bit first
    typedef struct packed {
        logic       rsvd;    // bit 7, reads 0
        logic       open;    // bit 6, reach SMRAM outside SMM
        logic       close;   // bit 5, SMM data goes to normal space
        logic       lock;    // bit 4, freeze until reset
        logic       gen;     // bit 3, global SMRAM enable
        logic [2:0] seg;     // bits 2:0, window segment select
    } smram_cfg_t;

endpackage

// File: rtl/smram_cfg_reg.sv
// Configuration register with write cleanup and lock.
// Cleans each write (reserved bit, open/close conflict, open dropped on
// lock) and blocks every write while locked. Assumes synchronous
// active-low reset is the only way to clear the lock.
module smram_cfg_reg
    import smram_pkg::*;
#(
    parameter logic [CFG_W-1:0] RESET_VAL = CFG_RESET
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output smram_cfg_t       cfg_o
);

    smram_cfg_t cfg_q;
    smram_cfg_t wr_clean;

    // Turn the raw write value into a legal register value
    always_comb begin
        wr_clean      = smram_cfg_t'(wr_data);
        wr_clean.rsvd = 1'b0;
        if (wr_clean.open && wr_clean.close) begin
            wr_clean.close = 1'b0;
        end
        if (wr_clean.lock) begin
            wr_clean.open = 1'b0;
        end
    end

    // Store the cleaned value unless the register is locked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= smram_cfg_t'(RESET_VAL);
        end else if (wr_en && !cfg_q.lock) begin
            cfg_q <= wr_clean;
        end
    end

    assign cfg_o = cfg_q;

    // R4: once locked, nothing changes until reset
    p_lock_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.lock |=> $stable(cfg_q));

    // R4: a locked register never holds open
    p_locked_shut_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.lock |-> !cfg_q.open);

    // R3: open and close are never stored together
    p_no_dual_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_q.open && cfg_q.close));

    // R2: reserved bit always reads 0
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.rsvd);

    // R2: an unlocked write lands on the next edge
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cfg_q.lock) |=>
            (cfg_q.gen == $past(wr_data[3]) && cfg_q.seg == $past(wr_data[2:0])
             && cfg_q.lock == $past(wr_data[4])));

endmodule

// File: rtl/smram_win_match.sv
// Address window comparator.
// Flags addresses inside the inclusive range [WIN_BASE, WIN_LAST].
// Assumes WIN_BASE <= WIN_LAST. A zero base drops the lower compare.
module smram_win_match #(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE = 'h000A_0000,
    parameter logic [ADDR_W-1:0] WIN_LAST = 'h000B_FFFF
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    logic above_base;

    // Lower bound, built only when the base is not zero
    generate
        if (WIN_BASE == '0) begin : g_no_low
            assign above_base = 1'b1;
        end else begin : g_low
            assign above_base = (addr >= WIN_BASE);
        end
    endgenerate

    // Combine both bounds
    always_comb begin
        hit = above_base && (addr <= WIN_LAST);
    end

endmodule

// File: rtl/smram_route_dec.sv
// Routing decision for one access.
// Combines the register view, the window hit, SMM mode and access kind.
// Assumes the register never holds open and close together.
// Clock and reset feed only the assertions.
module smram_route_dec
    import smram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  smram_cfg_t cfg,
    input  logic       win_hit,
    input  logic       in_smm,
    input  logic       is_fetch,
    output logic       to_smram
);

    logic seg_ok;
    logic armed;

    // Window active: globally enabled, legacy segment, address inside
    always_comb begin
        seg_ok = (cfg.seg == SEG_LEGACY);
        armed  = cfg.gen && seg_ok && win_hit;
    end

    // Choose SMRAM or normal space from mode and access kind
    always_comb begin
        if (!armed) begin
            to_smram = 1'b0;
        end else if (cfg.open) begin
            to_smram = 1'b1;
        end else if (in_smm) begin
            to_smram = !cfg.close || is_fetch;
        end else begin
            to_smram = 1'b0;
        end
    end

    // R5: global enable off never reaches SMRAM
    p_gen_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.gen |-> !to_smram);

    // R9: outside the window never reaches SMRAM
    p_outside_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !win_hit |-> !to_smram);

    // R10: other segment codes never reach SMRAM
    p_seg_other_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.seg != SEG_LEGACY) |-> !to_smram);

    // R6: open window reachable from outside SMM
    p_open_reach_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.open && cfg.gen && seg_ok && win_hit && !in_smm) |-> to_smram);

    // R7: closed-open window unreachable outside SMM
    p_smm_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.open && !in_smm) |-> !to_smram);

    // R8: close steers SMM data away, fetches stay
    p_close_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.close && !cfg.open && !is_fetch) |-> !to_smram);

endmodule

// File: rtl/smram_window_ctl.sv
// SMRAM window control, top level.
// Holds the window configuration register and routes each access to
// SMRAM or to normal space. Assumes one access is presented per cycle
// and the address is a byte address of ADDR_W bits.
module smram_window_ctl
    import smram_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 'h000A_0000,
    parameter logic [ADDR_W-1:0] WIN_LAST  = 'h000B_FFFF,
    parameter logic [7:0]        RESET_VAL = CFG_RESET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              cpu_in_smm,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_fetch,
    output logic              acc_to_smram
);

    smram_cfg_t cfg;
    logic       hit;

    // Register with lock and write cleanup
    smram_cfg_reg #(
        .RESET_VAL (RESET_VAL)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .cfg_o   (cfg)
    );

    // Address window compare
    smram_win_match #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE),
        .WIN_LAST (WIN_LAST)
    ) u_win (
        .addr (acc_addr),
        .hit  (hit)
    );

    // Route decision
    smram_route_dec u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg),
        .win_hit  (hit),
        .in_smm   (cpu_in_smm),
        .is_fetch (acc_fetch),
        .to_smram (acc_to_smram)
    );

    // Expose the stored register
    assign cfg_rdata = 8'(cfg);

endmodule

// File: tb/test_smram_window_ctl.sv
module test_smram_window_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        cpu_in_smm = 1'b0;
    logic [31:0] acc_addr = 32'h0;
    logic        acc_fetch = 1'b0;
    logic        acc_to_smram;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    smram_window_ctl i_smram_window_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .cpu_in_smm   (cpu_in_smm),
        .acc_addr     (acc_addr),
        .acc_fetch    (acc_fetch),
        .acc_to_smram (acc_to_smram)
    );

    // {wdata, smm, fetch, addr, expected read, expected route, req}
    localparam int NV = 13;
    localparam logic [58:0] VEC [NV] = '{
        {8'h0A, 1'b0, 1'b0, 32'h000A0000, 8'h0A, 1'b0, 8'd7},   // R7 outside SMM
        {8'h0A, 1'b1, 1'b0, 32'h000A0000, 8'h0A, 1'b1, 8'd7},   // R7 in SMM
        {8'h4A, 1'b0, 1'b0, 32'h000BFFFF, 8'h4A, 1'b1, 8'd6},   // R6 open, top edge
        {8'h4A, 1'b0, 1'b0, 32'h000C0000, 8'h4A, 1'b0, 8'd9},   // R9 just above
        {8'h4A, 1'b1, 1'b0, 32'h0009FFFF, 8'h4A, 1'b0, 8'd9},   // R9 just below
        {8'h42, 1'b1, 1'b0, 32'h000A0000, 8'h42, 1'b0, 8'd5},   // R5 gen off
        {8'h2A, 1'b1, 1'b0, 32'h000A8000, 8'h2A, 1'b0, 8'd8},   // R8 data
        {8'h2A, 1'b1, 1'b1, 32'h000A8000, 8'h2A, 1'b1, 8'd8},   // R8 fetch
        {8'h2A, 1'b0, 1'b1, 32'h000A8000, 8'h2A, 1'b0, 8'd8},   // R8 fetch outside SMM
        {8'h6A, 1'b0, 1'b0, 32'h000A0000, 8'h4A, 1'b1, 8'd3},   // R3 both set
        {8'h4B, 1'b0, 1'b0, 32'h000A0000, 8'h4B, 1'b0, 8'd10},  // R10 code 011
        {8'hCA, 1'b0, 1'b0, 32'h000B0000, 8'h4A, 1'b1, 8'd2},   // R2 bit 7 dropped
        {8'h08, 1'b1, 1'b1, 32'h000A0000, 8'h08, 1'b0, 8'd10}   // R10 code 000
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic access(input logic smm, input logic fetch, input logic [31:0] a);
        cpu_in_smm = smm;
        acc_fetch  = fetch;
        acc_addr   = a;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();

        // R1: reset state
        access(1'b1, 1'b0, 32'h000A0000);
        chk("R1 rdata", 32'(cfg_rdata), 32'h02);
        chk("R1 route", 32'(acc_to_smram), 32'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][58:51]);
            access(VEC[i][50], VEC[i][49], VEC[i][48:17]);
            chk($sformatf("R%0d rdata v%0d", VEC[i][7:0], i), 32'(cfg_rdata), 32'(VEC[i][16:9]));
            chk($sformatf("R%0d route v%0d", VEC[i][7:0], i), 32'(acc_to_smram), 32'(VEC[i][8]));
        end

        // R2: write and access in the same cycle
        do_reset();
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = 8'h4A;
        access(1'b0, 1'b0, 32'h000A0000);
        chk("R2 same-cycle route", 32'(acc_to_smram), 32'h0);
        chk("R2 same-cycle rdata", 32'(cfg_rdata), 32'h02);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        chk("R2 next-cycle route", 32'(acc_to_smram), 32'h1);
        chk("R2 next-cycle rdata", 32'(cfg_rdata), 32'h4A);

        // R4: lock drops open
        do_write(8'h5A);
        access(1'b0, 1'b0, 32'h000A0000);
        chk("R4 lock rdata", 32'(cfg_rdata), 32'h1A);
        chk("R4 lock route outside SMM", 32'(acc_to_smram), 32'h0);
        access(1'b1, 1'b0, 32'h000A0000);
        chk("R4 lock route in SMM", 32'(acc_to_smram), 32'h1);

        // R4: writes ignored after lock
        do_write(8'h4A);
        access(1'b0, 1'b0, 32'h000A0000);
        chk("R4 reopen ignored rdata", 32'(cfg_rdata), 32'h1A);
        chk("R4 reopen ignored route", 32'(acc_to_smram), 32'h0);
        do_write(8'h00);
        access(1'b1, 1'b0, 32'h000A0000);
        chk("R4 clear ignored rdata", 32'(cfg_rdata), 32'h1A);
        chk("R4 clear ignored route", 32'(acc_to_smram), 32'h1);

        // R4: reset lifts the lock
        do_reset();
        #1;
        chk("R4 reset rdata", 32'(cfg_rdata), 32'h02);
        do_write(8'h4A);
        access(1'b0, 1'b0, 32'h000A0000);
        chk("R4 write after reset", 32'(cfg_rdata), 32'h4A);
        chk("R6 route after reset", 32'(acc_to_smram), 32'h1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule